// File: doc/BRIEF.md
# Descriptor Entry Chain Walker

This block traverses the list of variable-length records that follows a descriptor header in a byte-addressed store. It reads bytes through a synchronous read port with one cycle of latency. The walk begins at byte 22 and continues until the running position reaches the total descriptor size given on its input. Each record starts with a two-byte header. Byte 0 is the record length, and that length counts the header itself. Byte 1 holds a 6-bit index, a disabled flag and a type bit. After each record the position moves forward by that record's length.

Port records produce a port result on a one-cycle valid strobe. Name records with index 1 or 2 produce a string locator, which is the byte offset and length of the name text. The text itself is left in the store. Every read and every step is checked against the total size, so a malformed chain ends the walk with an error code. Port records whose index is above a configured ceiling are skipped quietly. A per-port input marks which ports are lane ports, and only lane ports have their link fields decoded. The walk ends with a one-cycle done strobe that carries the error code.

The size, ceiling and lane-port inputs must stay stable while a walk runs.

Top module: `desc_walker`

## Requirements
- R1: A start pulse seen while idle begins a walk whose first read is at byte 22. If the size is 22 or less, the walk ends at once with done and code 0 (none), and no read or record occurs.
- R2: Header byte 0 is the record length. Header byte 1 holds the index in bits 5:0, the disabled flag in bit 6, and the type in bit 7 (0 = name record, 1 = port record).
- R3: The walk stops with done and code 1 (overrun) in three cases: the position plus 1 equals the size, the position plus the length exceeds the size, or the length is zero. No record is produced after the error.
- R4: After each record is handled, the position moves forward by that record's length.
- R5: A port record whose index is greater than `max_port_i` produces no output and no error, and the walk continues.
- R6: A port record with the disabled flag set (bit 6) produces a record with `port_dis_o`=1 and with link, partner-valid and partner number all 0, whatever its length.
- R7: An enabled port record whose index has its `lane_port_i` bit set must be exactly 8 bytes long. Any other length ends the walk with done and code 2 (bad port length).
- R8: For an enabled lane port, the link number comes from bit 4 of record byte 2, and partner-valid comes from bit 7 of byte 2. The partner number comes from bits 5:0 of byte 3 and reads as 0 when partner-valid is 0.
- R9: An enabled port whose `lane_port_i` bit is clear produces a record with link, partner-valid and partner number all 0, and no length check is made.
- R10: A name record with index 1 gives `str_kind_o`=0, and one with index 2 gives `str_kind_o`=1. In both, the offset is the record position plus 2 and the length is the record length minus 2. Name records with any other index produce nothing.
- R11: While a walk is in progress, start is ignored. Each walk raises done for exactly one cycle, and busy is low in that cycle.
- R12: No read is ever issued at an address equal to or beyond the size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| total_size_i | input | ADDR_W | Descriptor size in bytes |
| max_port_i | input | 6 | Highest port index that is accepted |
| lane_port_i | input | 64 | Per-index lane-port flag |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_data_i | input | 8 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Walk in progress |
| port_vld_o | output | 1 | Port record strobe |
| port_idx_o | output | 6 | Port index |
| port_dis_o | output | 1 | Port disabled |
| port_link_o | output | 1 | Link number |
| port_dual_o | output | 1 | Partner valid |
| port_peer_o | output | 6 | Partner port number |
| str_vld_o | output | 1 | String locator strobe |
| str_kind_o | output | 1 | 0 vendor name, 1 device name |
| str_ofs_o | output | ADDR_W | Byte offset of the text |
| str_len_o | output | 8 | Text length |
| done_o | output | 1 | Walk finished strobe |
| err_o | output | 2 | Code valid with done: 0 none, 1 overrun, 2 bad port length |

## Verification
The hardest conditions to reach are the ones that appear only deep in a chain. One is a lane-port record that is handled correctly only if the earlier variable-length records moved the position by exactly their lengths. Another is an error that must stop a walk that would otherwise produce more records. The bench builds mixed chains in its byte-store model: a name record, then a lane port, then a non-lane port, then a second name record. It checks the offset of the last string and the fields of each port. A chain with a bad lane-port length placed before a valid name record shows that nothing is produced after the error. A second start pulsed in the middle of a walk confirms that start is ignored while busy.

// File: rtl/dwalk_pkg.sv
// Shared constants and types for the descriptor chain walker.
// Assumes the record header layout: byte0 = length, byte1 = {type, off, idx}.
package dwalk_pkg;

    localparam int unsigned IDX_W       = 6;
    localparam int unsigned CHAIN_START = 22;
    localparam logic [7:0]  HDR_BYTES   = 8'd2;
    localparam logic [7:0]  PORT_REC_LEN = 8'd8;

    typedef enum logic [1:0] {
        WERR_NONE     = 2'd0,
        WERR_OVERRUN  = 2'd1,
        WERR_PORT_LEN = 2'd2
    } werr_e;

    typedef enum logic [2:0] {
        ACT_SKIP,
        ACT_STRING,
        ACT_PORT_OFF,
        ACT_PORT_PLAIN,
        ACT_PORT_LANE,
        ACT_BAD_LEN
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POS,
        ST_LEN,
        ST_HDR,
        ST_CHK,
        ST_B2,
        ST_B3
    } wstate_e;

    typedef struct packed {
        logic             is_port;
        logic             off;
        logic [IDX_W-1:0] idx;
    } ehdr_t;

endpackage

// File: rtl/walk_bounds.sv
// Bounds arithmetic for the chain walk.
// Computes end-of-chain, tail-byte overrun, bad-length overrun and next position.
// Assumes len_i belongs to the record at pos_i.
module walk_bounds #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pos_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic [7:0]        len_i,
    output logic              at_end_o,
    output logic              tail_o,
    output logic              len_bad_o,
    output logic [ADDR_W-1:0] next_o
);
    localparam int unsigned WX = ADDR_W + 1;

    logic [WX-1:0] pos_x;
    logic [WX-1:0] size_x;
    logic [WX-1:0] end_x;

    // Widen operands by one bit so sums never wrap.
    always_comb begin
        pos_x  = {1'b0, pos_i};
        size_x = {1'b0, size_i};
        end_x  = pos_x + WX'(len_i);
    end

    // Boundary decisions.
    always_comb begin
        at_end_o  = (pos_i >= size_i);
        tail_o    = ((pos_x + WX'(1)) == size_x);
        len_bad_o = (len_i == 8'd0) || (end_x > size_x);
        next_o    = end_x[ADDR_W-1:0];
    end
endmodule

// File: rtl/entry_classify.sv
// Decides what to do with one record from its header and length.
// Assumes hdr_i and len_i are captured and lane_i is the lane flag for hdr_i.idx.
module entry_classify
    import dwalk_pkg::*;
(
    input  ehdr_t            hdr_i,
    input  logic [7:0]       len_i,
    input  logic [IDX_W-1:0] max_port_i,
    input  logic             lane_i,
    output act_e             act_o,
    output logic             str_kind_o
);
    // Priority: type, index ceiling, disabled, lane, length.
    always_comb begin
        act_o      = ACT_SKIP;
        str_kind_o = 1'b0;
        if (!hdr_i.is_port) begin
            if (hdr_i.idx == IDX_W'(1) || hdr_i.idx == IDX_W'(2)) begin
                act_o      = ACT_STRING;
                str_kind_o = (hdr_i.idx == IDX_W'(2));
            end
        end else if (hdr_i.idx > max_port_i) begin
            act_o = ACT_SKIP;
        end else if (hdr_i.off) begin
            act_o = ACT_PORT_OFF;
        end else if (!lane_i) begin
            act_o = ACT_PORT_PLAIN;
        end else if (len_i != PORT_REC_LEN) begin
            act_o = ACT_BAD_LEN;
        end else begin
            act_o = ACT_PORT_LANE;
        end
    end
endmodule

// File: rtl/record_out.sv
// Output register stage: one-cycle strobes for port records, string locators
// and the finish event. Fields hold between strobes; err is zero without done.
module record_out
    import dwalk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_port_i,
    input  logic [IDX_W-1:0]  port_idx_i,
    input  logic              port_dis_i,
    input  logic              port_link_i,
    input  logic              port_dual_i,
    input  logic [IDX_W-1:0]  port_peer_i,
    input  logic              emit_str_i,
    input  logic              str_kind_i,
    input  logic [ADDR_W-1:0] str_ofs_i,
    input  logic [7:0]        str_len_i,
    input  logic              fin_i,
    input  werr_e             fin_err_i,
    output logic              port_vld_o,
    output logic [IDX_W-1:0]  port_idx_o,
    output logic              port_dis_o,
    output logic              port_link_o,
    output logic              port_dual_o,
    output logic [IDX_W-1:0]  port_peer_o,
    output logic              str_vld_o,
    output logic              str_kind_o,
    output logic [ADDR_W-1:0] str_ofs_o,
    output logic [7:0]        str_len_o,
    output logic              done_o,
    output logic [1:0]        err_o
);
    // Port record register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_vld_o  <= 1'b0;
            port_idx_o  <= '0;
            port_dis_o  <= 1'b0;
            port_link_o <= 1'b0;
            port_dual_o <= 1'b0;
            port_peer_o <= '0;
        end else begin
            port_vld_o <= emit_port_i;
            if (emit_port_i) begin
                port_idx_o  <= port_idx_i;
                port_dis_o  <= port_dis_i;
                port_link_o <= port_link_i;
                port_dual_o <= port_dual_i;
                port_peer_o <= port_peer_i;
            end
        end
    end

    // String locator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_vld_o  <= 1'b0;
            str_kind_o <= 1'b0;
            str_ofs_o  <= '0;
            str_len_o  <= '0;
        end else begin
            str_vld_o <= emit_str_i;
            if (emit_str_i) begin
                str_kind_o <= str_kind_i;
                str_ofs_o  <= str_ofs_i;
                str_len_o  <= str_len_i;
            end
        end
    end

    // Finish strobe and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 2'd0;
        end else begin
            done_o <= fin_i;
            err_o  <= fin_i ? fin_err_i : WERR_NONE;
        end
    end

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_only_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != 2'd0) |-> done_o);

    p_off_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_vld_o && port_dis_o) |-> (!port_link_o && !port_dual_o && port_peer_o == '0));

    p_peer_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_vld_o && !port_dual_o) |-> (port_peer_o == '0));

    p_single_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_vld_o && str_vld_o));
endmodule

// File: rtl/desc_walker.sv
// Descriptor chain walker top: sequences byte reads over a length-prefixed
// record chain, bounds-checks each step and emits port and string results.
// Assumes a read port with one cycle latency and inputs stable during a walk.
module desc_walker
    import dwalk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ADDR_W-1:0]      total_size_i,
    input  logic [IDX_W-1:0]       max_port_i,
    input  logic [(1<<IDX_W)-1:0]  lane_port_i,
    output logic                   rd_en_o,
    output logic [ADDR_W-1:0]      rd_addr_o,
    input  logic [7:0]             rd_data_i,
    output logic                   busy_o,
    output logic                   port_vld_o,
    output logic [IDX_W-1:0]       port_idx_o,
    output logic                   port_dis_o,
    output logic                   port_link_o,
    output logic                   port_dual_o,
    output logic [IDX_W-1:0]       port_peer_o,
    output logic                   str_vld_o,
    output logic                   str_kind_o,
    output logic [ADDR_W-1:0]      str_ofs_o,
    output logic [7:0]             str_len_o,
    output logic                   done_o,
    output logic [1:0]             err_o
);
    localparam logic [ADDR_W-1:0] START_POS = ADDR_W'(CHAIN_START);

    wstate_e           state;
    logic [ADDR_W-1:0] pos;
    logic [7:0]        len_q;
    ehdr_t             hdr_q;
    logic              link_q;
    logic              dual_q;

    logic              at_end, tail, len_bad;
    logic [ADDR_W-1:0] next_pos;
    act_e              act;
    logic              kind;

    logic              emit_port, emit_str, fin;
    werr_e             fin_err;
    logic              o_link, o_dual;
    logic [IDX_W-1:0]  o_peer;
    logic [7:0]        s_len;

    walk_bounds #(.ADDR_W(ADDR_W)) i_bounds (
        .pos_i     (pos),
        .size_i    (total_size_i),
        .len_i     (len_q),
        .at_end_o  (at_end),
        .tail_o    (tail),
        .len_bad_o (len_bad),
        .next_o    (next_pos)
    );

    entry_classify i_classify (
        .hdr_i      (hdr_q),
        .len_i      (len_q),
        .max_port_i (max_port_i),
        .lane_i     (lane_port_i[hdr_q.idx]),
        .act_o      (act),
        .str_kind_o (kind)
    );

    // Sequencer state and captured record bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pos    <= '0;
            len_q  <= '0;
            hdr_q  <= '0;
            link_q <= 1'b0;
            dual_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    pos   <= START_POS;
                    state <= ST_POS;
                end
                ST_POS:  state <= (at_end || tail) ? ST_IDLE : ST_LEN;
                ST_LEN: begin
                    len_q <= rd_data_i;
                    state <= ST_HDR;
                end
                ST_HDR: begin
                    hdr_q <= ehdr_t'(rd_data_i);
                    state <= ST_CHK;
                end
                ST_CHK: begin
                    if (len_bad || act == ACT_BAD_LEN) begin
                        state <= ST_IDLE;
                    end else if (act == ACT_PORT_LANE) begin
                        state <= ST_B2;
                    end else begin
                        pos   <= next_pos;
                        state <= ST_POS;
                    end
                end
                ST_B2: begin
                    link_q <= rd_data_i[4];
                    dual_q <= rd_data_i[7];
                    state  <= ST_B3;
                end
                ST_B3: begin
                    pos   <= next_pos;
                    state <= ST_POS;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read requests, record emission and finish decisions per state.
    always_comb begin
        rd_en_o   = 1'b0;
        rd_addr_o = pos;
        emit_port = 1'b0;
        emit_str  = 1'b0;
        fin       = 1'b0;
        fin_err   = WERR_NONE;
        o_link    = 1'b0;
        o_dual    = 1'b0;
        o_peer    = '0;
        case (state)
            ST_POS: begin
                if (at_end) begin
                    fin = 1'b1;
                end else if (tail) begin
                    fin     = 1'b1;
                    fin_err = WERR_OVERRUN;
                end else begin
                    rd_en_o = 1'b1;
                end
            end
            ST_LEN: begin
                rd_en_o   = 1'b1;
                rd_addr_o = pos + ADDR_W'(1);
            end
            ST_CHK: begin
                if (len_bad) begin
                    fin     = 1'b1;
                    fin_err = WERR_OVERRUN;
                end else begin
                    case (act)
                        ACT_STRING:     emit_str  = 1'b1;
                        ACT_PORT_OFF:   emit_port = 1'b1;
                        ACT_PORT_PLAIN: emit_port = 1'b1;
                        ACT_BAD_LEN: begin
                            fin     = 1'b1;
                            fin_err = WERR_PORT_LEN;
                        end
                        ACT_PORT_LANE: begin
                            rd_en_o   = 1'b1;
                            rd_addr_o = pos + ADDR_W'(2);
                        end
                        default: ;
                    endcase
                end
            end
            ST_B2: begin
                rd_en_o   = 1'b1;
                rd_addr_o = pos + ADDR_W'(3);
            end
            ST_B3: begin
                emit_port = 1'b1;
                o_link    = link_q;
                o_dual    = dual_q;
                o_peer    = dual_q ? rd_data_i[IDX_W-1:0] : '0;
            end
            default: ;
        endcase
    end

    // String length excludes the two header bytes, never below zero.
    always_comb s_len = (len_q >= HDR_BYTES) ? (len_q - HDR_BYTES) : 8'd0;

    // Busy while not idle.
    always_comb busy_o = (state != ST_IDLE);

    record_out #(.ADDR_W(ADDR_W)) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .emit_port_i (emit_port),
        .port_idx_i  (hdr_q.idx),
        .port_dis_i  (hdr_q.off),
        .port_link_i (o_link),
        .port_dual_i (o_dual),
        .port_peer_i (o_peer),
        .emit_str_i  (emit_str),
        .str_kind_i  (kind),
        .str_ofs_i   (pos + ADDR_W'(2)),
        .str_len_i   (s_len),
        .fin_i       (fin),
        .fin_err_i   (fin_err),
        .port_vld_o  (port_vld_o),
        .port_idx_o  (port_idx_o),
        .port_dis_o  (port_dis_o),
        .port_link_o (port_link_o),
        .port_dual_o (port_dual_o),
        .port_peer_o (port_peer_o),
        .str_vld_o   (str_vld_o),
        .str_kind_o  (str_kind_o),
        .str_ofs_o   (str_ofs_o),
        .str_len_o   (str_len_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    p_read_in_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o < total_size_i));

    p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POS && $past(state) == ST_IDLE && rd_en_o) |-> (rd_addr_o == START_POS));

    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POS && $past(state) == ST_CHK) |->
        (pos == ADDR_W'($past(pos) + ADDR_W'($past(len_q)))));

    p_lane_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_B2) |-> (len_q == PORT_REC_LEN));
endmodule

// File: tb/test_desc_walker.sv
module test_desc_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 17;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] hdr;
        logic [7:0] b2;
        logic [7:0] b3;
        logic [7:0] size;
        logic       lane;
        logic       e_port;
        logic       e_str;
        logic [1:0] e_err;
        logic       e_dis;
        logic       e_link;
        logic       e_dual;
        logic [5:0] e_peer;
        logic       e_kind;
        logic [7:0] e_slen;
    } row_t;

    // One record at byte 22, max port 7.
    localparam row_t ROWS [NROWS] = '{
        '{8'd6, 8'h01, 8'h00, 8'h00, 8'd28, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd4}, // R10 vendor
        '{8'd5, 8'h02, 8'h00, 8'h00, 8'd27, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b1, 8'd3}, // R10 device
        '{8'd4, 8'h03, 8'h00, 8'h00, 8'd26, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R10 other index
        '{8'd8, 8'h83, 8'h90, 8'h05, 8'd30, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 6'd5,  1'b0, 8'd0}, // R8 lane port
        '{8'd8, 8'hC4, 8'h90, 8'h05, 8'd30, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R6 disabled
        '{8'd6, 8'h82, 8'h90, 8'h05, 8'd28, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R7 short lane
        '{8'd6, 8'h82, 8'h90, 8'h05, 8'd28, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R9 non-lane
        '{8'd3, 8'h89, 8'h00, 8'h00, 8'd25, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R5 idx 9 > 7
        '{8'd3, 8'hC1, 8'h00, 8'h00, 8'd25, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R6 disabled short
        '{8'd0, 8'h81, 8'h00, 8'h00, 8'd30, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R3 zero length
        '{8'd8, 8'h81, 8'h6F, 8'hFF, 8'd30, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R8 no partner
        '{8'd8, 8'h81, 8'h10, 8'h3F, 8'd28, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R3 past size
        '{8'd8, 8'h81, 8'h10, 8'h3F, 8'd23, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R3 tail byte
        '{8'd8, 8'h81, 8'h80, 8'h3F, 8'd30, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 6'd63, 1'b0, 8'd0}, // R8 partner 63
        '{8'd8, 8'h81, 8'h10, 8'h3F, 8'd20, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R1 size < 22
        '{8'd9, 8'h81, 8'h10, 8'h3F, 8'd31, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0,  1'b0, 8'd0}, // R7 long lane
        '{8'd8, 8'h87, 8'h10, 8'h00, 8'd30, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 6'd0,  1'b0, 8'd0}  // R5 idx == max, R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] size = 16'd0;
    logic [5:0]  maxp = 6'd7;
    logic [63:0] lane = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = 8'd0;
    logic        busy, port_vld, port_dis, port_link, port_dual;
    logic [5:0]  port_idx, port_peer;
    logic        str_vld, str_kind;
    logic [15:0] str_ofs;
    logic [7:0]  str_len;
    logic        done;
    logic [1:0]  err;

    logic [7:0]  mem [0:255];

    int n_checks = 0;
    int n_fail = 0;
    int n_port, n_str, n_done, n_oob;
    logic [14:0] first_port, last_port;
    logic [24:0] first_str, last_str;
    logic [1:0]  last_err;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_walker i_desc_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .total_size_i(size),
        .max_port_i(maxp), .lane_port_i(lane), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .busy_o(busy), .port_vld_o(port_vld), .port_idx_o(port_idx),
        .port_dis_o(port_dis), .port_link_o(port_link), .port_dual_o(port_dual),
        .port_peer_o(port_peer), .str_vld_o(str_vld), .str_kind_o(str_kind),
        .str_ofs_o(str_ofs), .str_len_o(str_len), .done_o(done), .err_o(err)
    );

    // Byte store model with one cycle read latency.
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rd_en && rd_addr >= size) n_oob++;
        if (port_vld) begin
            if (n_port == 0) first_port = {port_idx, port_dis, port_link, port_dual, port_peer};
            last_port = {port_idx, port_dis, port_link, port_dual, port_peer};
            n_port++;
        end
        if (str_vld) begin
            if (n_str == 0) first_str = {str_kind, str_ofs, str_len};
            last_str = {str_kind, str_ofs, str_len};
            n_str++;
        end
        if (done) begin
            n_done++;
            last_err = err;
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            n_checks++;
            n_fail++;
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 256; a++) mem[a] = 8'd0;
    endtask

    task automatic run_walk(input logic [15:0] sz, input logic [63:0] lm, input logic [5:0] mx);
        n_port = 0; n_str = 0; n_done = 0; n_oob = 0; last_err = 2'd0;
        first_port = '0; last_port = '0; first_str = '0; last_str = '0;
        size = sz; lane = lm; maxp = mx;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 3000 && n_done == 0; k++) @(negedge clk);
        if (n_done == 0) chk(1'b0, "R11 walk timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        n_port = 0; n_str = 0; n_done = 0; n_oob = 0;
        clear_mem();
        repeat (3) @(negedge clk);
        // Reset state
        chk(!busy && !done && !port_vld && !str_vld && !rd_en && err == 2'd0,
            "R11 reset outputs idle", {busy, done, port_vld, str_vld, rd_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: one record each
        for (int r = 0; r < NROWS; r++) begin
            clear_mem();
            mem[22] = ROWS[r].len; mem[23] = ROWS[r].hdr;
            mem[24] = ROWS[r].b2;  mem[25] = ROWS[r].b3;
            run_walk({8'd0, ROWS[r].size}, ROWS[r].lane ? '1 : '0, 6'd7);
            chk(n_done == 1, $sformatf("R11 row %0d done count", r), n_done, 1);
            chk(last_err == ROWS[r].e_err, $sformatf("R3 R7 row %0d code", r), last_err, ROWS[r].e_err);
            chk(n_port == int'(ROWS[r].e_port), $sformatf("R5 R6 R9 row %0d port count", r), n_port, ROWS[r].e_port);
            chk(n_str == int'(ROWS[r].e_str), $sformatf("R10 row %0d string count", r), n_str, ROWS[r].e_str);
            chk(n_oob == 0, $sformatf("R12 row %0d read range", r), n_oob, 0);
            if (ROWS[r].e_port)
                chk(last_port == {ROWS[r].hdr[5:0], ROWS[r].e_dis, ROWS[r].e_link, ROWS[r].e_dual, ROWS[r].e_peer},
                    $sformatf("R2 R8 row %0d port fields", r), last_port,
                    {ROWS[r].hdr[5:0], ROWS[r].e_dis, ROWS[r].e_link, ROWS[r].e_dual, ROWS[r].e_peer});
            if (ROWS[r].e_str)
                chk(last_str == {ROWS[r].e_kind, 16'd24, ROWS[r].e_slen},
                    $sformatf("R10 row %0d string locator", r), last_str,
                    {ROWS[r].e_kind, 16'd24, ROWS[r].e_slen});
        end

        // Mixed chain: R4 position advance and R1 start offset
        clear_mem();
        mem[22] = 8'd5; mem[23] = 8'h01;
        mem[27] = 8'd8; mem[28] = 8'h81; mem[29] = 8'h10; mem[30] = 8'h00;
        mem[35] = 8'd4; mem[36] = 8'h82;
        mem[39] = 8'd4; mem[40] = 8'h02;
        run_walk(16'd43, 64'h2, 6'd7);
        chk(n_port == 2 && n_str == 2, "R4 chain record counts", {n_port[7:0], n_str[7:0]}, 16'h0202);
        chk(first_str == {1'b0, 16'd24, 8'd3}, "R1 chain first string", first_str, {1'b0, 16'd24, 8'd3});
        chk(last_str == {1'b1, 16'd41, 8'd2}, "R4 chain last string", last_str, {1'b1, 16'd41, 8'd2});
        chk(first_port == {6'd1, 1'b0, 1'b1, 1'b0, 6'd0}, "R8 chain lane port", first_port, {6'd1, 1'b0, 1'b1, 1'b0, 6'd0});
        chk(last_port == {6'd2, 1'b0, 1'b0, 1'b0, 6'd0}, "R9 chain plain port", last_port, {6'd2, 1'b0, 1'b0, 1'b0, 6'd0});
        chk(last_err == 2'd0 && n_oob == 0, "R12 chain clean end", last_err, 0);

        // Error stops the walk: bad lane length before a name record
        clear_mem();
        mem[22] = 8'd6; mem[23] = 8'h81;
        mem[28] = 8'd6; mem[29] = 8'h01;
        run_walk(16'd40, 64'h2, 6'd7);
        chk(last_err == 2'd2 && n_str == 0 && n_port == 0, "R7 error halts walk", {last_err, n_str[3:0]}, 6'h20);

        // Ceiling: index 8 skipped, following record still handled (R5)
        clear_mem();
        mem[22] = 8'd8; mem[23] = 8'h88;
        mem[30] = 8'd4; mem[31] = 8'h02;
        run_walk(16'd34, '1, 6'd7);
        chk(n_port == 0 && n_str == 1 && last_err == 2'd0, "R5 skip then continue", {n_port[3:0], n_str[3:0]}, 8'h01);

        // Start ignored while busy (R11)
        clear_mem();
        mem[22] = 8'd5; mem[23] = 8'h01;
        mem[27] = 8'd8; mem[28] = 8'h81; mem[29] = 8'h10;
        mem[35] = 8'd4; mem[36] = 8'h82;
        mem[39] = 8'd4; mem[40] = 8'h02;
        n_port = 0; n_str = 0; n_done = 0; n_oob = 0;
        size = 16'd43; lane = 64'h2; maxp = 6'd7;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R11 busy mid walk", busy, 1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 3000 && n_done == 0; k++) @(negedge clk);
        chk(busy == 1'b0, "R11 busy low at done", busy, 0);
        repeat (20) @(negedge clk);
        chk(n_done == 1 && n_port == 2 && n_str == 2, "R11 restart ignored",
            {n_done[3:0], n_port[3:0], n_str[3:0]}, 12'h122);

        report();
        $finish;
    end
endmodule